// File: doc/BRIEF.md
# Adaptive Lookup-Table Complex Predistorter

This block is the streaming forward path of a table-driven amplifier linearizer. Every clock it can take one complex baseband sample, form a table address from the sample's instantaneous power, fetch a complex correction coefficient from an on-chip table, and multiply the sample by that coefficient. The result is the predistorted sample that goes on to the converter. The sample is held back inside the block by exactly the time the address and the table read take, so each sample is multiplied by the coefficient chosen for it.

A second table port takes cartesian coefficient writes (address, real part, imaginary part) from an external adaptation engine while the stream keeps running. To let that engine compare the amplifier output with what was sent, the block also exports a copy of each input sample and its table address. Both are delayed by one fixed, compile-time loop delay, so the sample and its address stay aligned. After reset the table fills itself with unity coefficients, one entry per clock, before it accepts external writes.

Top module: `lut_predistorter`

## Requirements
- R1: The table address is p >> (2·IW−1−AW), where p = I²+Q² is taken from the signed IW-bit input. When p ≥ 2^(2·IW−1) the address is 2^AW−1. With the defaults the shift is 19 and p ≥ 2^27 selects address 255.
- R2: After reset is released, the table spends 2^AW cycles writing unity into every entry (real = 2^(CW−2), imaginary = 0). From then on, a sample whose entry has not been rewritten comes out unchanged.
- R3: A write presented on the table write port during the post-reset fill is discarded. The entry still reads as unity afterwards.
- R4: The predistorted sample is (x_i·c_i − x_q·c_q, x_i·c_q + x_q·c_i). Each part has 2^(CW−3) added and is then shifted arithmetically right by CW−2, which rounds half up.
- R5: Each predistorted part that falls outside the signed IW-bit range is clamped to 2^(IW−1)−1 or −2^(IW−1).
- R6: Each sample uses the coefficient stored at its own address. A write to one address does not change the output for samples that map to another address.
- R7: Writes are accepted while samples stream. A sample captured at clock edge n reads the table at edge n+2. A write captured at that same edge to the same address is not seen by that sample, while a write captured at edge n+1 is seen.
- R8: fb_i and fb_q repeat the input sample LOOP_DLY cycles later, counted as register stages. fb_idx carries that same sample's table address in the same cycle. LOOP_DLY must be at least 3.
- R9: pd_vld rises exactly 5 cycles after in_vld for the same sample, and fb_vld rises LOOP_DLY cycles after it. Both are 0 during reset and for cycles with in_vld low. All registered outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample valid |
| in_i | input | IW | Input real part, signed |
| in_q | input | IW | Input imaginary part, signed |
| tw_en | input | 1 | Table write enable |
| tw_addr | input | AW | Table write address |
| tw_i | input | CW | Coefficient real part, signed, CW−2 fraction bits |
| tw_q | input | CW | Coefficient imaginary part, signed |
| pd_vld | output | 1 | Predistorted sample valid |
| pd_i | output | IW | Predistorted real part |
| pd_q | output | IW | Predistorted imaginary part |
| fb_vld | output | 1 | Delayed feedback copy valid |
| fb_i | output | IW | Delayed input real part |
| fb_q | output | IW | Delayed input imaginary part |
| fb_idx | output | AW | Table address of the delayed sample |

## Verification
The table read for a streaming sample and a coefficient write from the adaptation side can hit the same address in the same clock. The bench provokes this by timing a write to a sample's address so that it is captured at the sample's read edge, and then, for another sample, one edge earlier. The scoreboard's table model applies each write only after it has resolved the samples that read in that cycle. The first sample must therefore come out with the old coefficient and the second with the new one, and both are compared at the exact output cycle.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // Fill state of the correction table after reset
  typedef enum logic {
    TBL_FILL = 1'b0,
    TBL_LIVE = 1'b1
  } tbl_state_e;

  // Register stages on the forward path
  localparam int PD_IDX_STAGES = 2;  // square, then sum/clip
  localparam int PD_RD_STAGES  = 1;  // table read register
  localparam int PD_MUL_STAGES = 2;  // products, then round/clamp

endpackage

// File: rtl/pd_delay.sv
module pd_delay #(
  parameter int W = 1,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [N];

  for (genvar k = 0; k < N; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage[k] <= '0;
      end else if (k == 0) begin
        stage[k] <= d;
      end else begin
        stage[k] <= stage[(k == 0) ? 0 : k-1];
      end
    end
  end

  assign q = stage[N-1];

endmodule

// File: rtl/pd_power_index.sv
module pd_power_index #(
  parameter int IW = 14,
  parameter int AW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [IW-1:0] in_i,
  input  logic signed [IW-1:0] in_q,
  output logic                 o_vld,
  output logic [AW-1:0]        o_idx
);

  localparam int PW = 2*IW;
  localparam int SH = PW - 1 - AW;

  logic [PW-2:0] sq_i, sq_q, sq_i_nxt, sq_q_nxt;
  logic          s1_vld;
  logic [PW-1:0] pwr;
  logic [PW-1:0] pwr_sh;

  assign sq_i_nxt = (PW-1)'(PW'(in_i) * PW'(in_i));
  assign sq_q_nxt = (PW-1)'(PW'(in_q) * PW'(in_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      sq_i   <= '0;
      sq_q   <= '0;
    end else begin
      s1_vld <= in_vld;
      sq_i   <= sq_i_nxt;
      sq_q   <= sq_q_nxt;
    end
  end

  assign pwr    = {1'b0, sq_i} + {1'b0, sq_q};
  assign pwr_sh = pwr >> SH;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
      o_idx <= '0;
    end else begin
      o_vld <= s1_vld;
      o_idx <= pwr[PW-1] ? '1 : AW'(pwr_sh);
    end
  end

  // R1: a zero sample must land on address 0
  p_zero_idx_r1: assert property (@(posedge clk) disable iff (rst)
    (o_vld && $past(in_i, 2) == '0 && $past(in_q, 2) == '0) |-> (o_idx == '0));

  // R1: the most negative corner clips to the top address
  p_clip_idx_r1: assert property (@(posedge clk) disable iff (rst)
    (o_vld && $past(in_i, 2) == {1'b1, {(IW-1){1'b0}}} &&
     $past(in_q, 2) == {1'b1, {(IW-1){1'b0}}}) |-> (o_idx == '1));

endmodule

// File: rtl/pd_corr_table.sv
module pd_corr_table
  import pd_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        rd_addr,
  output logic signed [CW-1:0] rd_i,
  output logic signed [CW-1:0] rd_q,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [CW-1:0] wr_i,
  input  logic signed [CW-1:0] wr_q
);

  localparam int DEPTH = 1 << AW;
  localparam int WW    = 2*CW;
  localparam logic [CW-1:0] UNITY = CW'(1 << (CW-2));

  logic [WW-1:0] mem [DEPTH];
  logic [WW-1:0] rd_word;
  tbl_state_e    st;
  logic [AW-1:0] fill_addr;
  logic          we;
  logic [AW-1:0] wa;
  logic [WW-1:0] wd;

  // Post-reset fill sweep
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TBL_FILL;
      fill_addr <= '0;
    end else if (st == TBL_FILL) begin
      fill_addr <= fill_addr + 1'b1;
      if (fill_addr == '1) st <= TBL_LIVE;
    end
  end

  // The single write port is owned by the sweep until the fill finishes
  always_comb begin
    if (st == TBL_FILL) begin
      we = 1'b1;
      wa = fill_addr;
      wd = {UNITY, {CW{1'b0}}};
    end else begin
      we = wr_en;
      wa = wr_addr;
      wd = {wr_i, wr_q};
    end
  end

  // Simple dual-port RAM with registered read, old data on collision
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd_word <= mem[rd_addr];
  end

  assign rd_i = rd_word[WW-1:CW];
  assign rd_q = rd_word[CW-1:0];

  // R2: the sweep visits consecutive addresses
  p_fill_step_r2: assert property (@(posedge clk) disable iff (rst)
    (st == TBL_FILL) |=> (st == TBL_LIVE || fill_addr == AW'($past(fill_addr) + 1'b1)));

  // R2: once live, the table never re-enters the fill
  p_fill_once_r2: assert property (@(posedge clk) disable iff (rst)
    (st == TBL_LIVE) |=> (st == TBL_LIVE));

endmodule

// File: rtl/pd_cmul.sv
module pd_cmul #(
  parameter int IW = 14,
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] x_q,
  input  logic signed [CW-1:0] c_i,
  input  logic signed [CW-1:0] c_q,
  output logic                 o_vld,
  output logic signed [IW-1:0] o_i,
  output logic signed [IW-1:0] o_q
);

  localparam int PRW  = IW + CW;
  localparam int SW   = PRW + 1;
  localparam int FRAC = CW - 2;
  localparam logic signed [SW-1:0] HALF = SW'(1 << (FRAC-1));
  localparam logic signed [SW-1:0] MAXV = SW'((1 << (IW-1)) - 1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);
  localparam logic signed [CW-1:0] C_ONE = CW'(1 << FRAC);

  logic signed [PRW-1:0] p_ii, p_qq, p_iq, p_qi;
  logic                  s1_vld;
  logic signed [SW-1:0]  re_sum, im_sum, re_rnd, im_rnd;

  function automatic logic signed [IW-1:0] clamp(input logic signed [SW-1:0] v);
    if (v > MAXV)      return MAXV[IW-1:0];
    else if (v < MINV) return MINV[IW-1:0];
    else               return v[IW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      p_ii <= '0; p_qq <= '0; p_iq <= '0; p_qi <= '0;
    end else begin
      s1_vld <= in_vld;
      p_ii <= PRW'(x_i) * PRW'(c_i);
      p_qq <= PRW'(x_q) * PRW'(c_q);
      p_iq <= PRW'(x_i) * PRW'(c_q);
      p_qi <= PRW'(x_q) * PRW'(c_i);
    end
  end

  assign re_sum = SW'(p_ii) - SW'(p_qq);
  assign im_sum = SW'(p_iq) + SW'(p_qi);
  assign re_rnd = (re_sum + HALF) >>> FRAC;
  assign im_rnd = (im_sum + HALF) >>> FRAC;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
      o_i   <= '0;
      o_q   <= '0;
    end else begin
      o_vld <= s1_vld;
      o_i   <= clamp(re_rnd);
      o_q   <= clamp(im_rnd);
    end
  end

  // R4: a unity coefficient passes the sample through untouched
  p_unity_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (o_vld && $past(c_i, 2) == C_ONE && $past(c_q, 2) == '0)
      |-> (o_i == $past(x_i, 2) && o_q == $past(x_q, 2)));

  // R4: a zero coefficient yields a zero output
  p_zero_coef_r4: assert property (@(posedge clk) disable iff (rst)
    (o_vld && $past(c_i, 2) == '0 && $past(c_q, 2) == '0) |-> (o_i == '0 && o_q == '0));

endmodule

// File: rtl/lut_predistorter.sv
module lut_predistorter
  import pd_pkg::*;
#(
  parameter int IW       = 14,
  parameter int CW       = 12,
  parameter int AW       = 8,
  parameter int LOOP_DLY = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [IW-1:0] in_i,
  input  logic signed [IW-1:0] in_q,
  input  logic                 tw_en,
  input  logic [AW-1:0]        tw_addr,
  input  logic signed [CW-1:0] tw_i,
  input  logic signed [CW-1:0] tw_q,
  output logic                 pd_vld,
  output logic signed [IW-1:0] pd_i,
  output logic signed [IW-1:0] pd_q,
  output logic                 fb_vld,
  output logic signed [IW-1:0] fb_i,
  output logic signed [IW-1:0] fb_q,
  output logic [AW-1:0]        fb_idx
);

  localparam int ALIGN      = PD_IDX_STAGES + PD_RD_STAGES;
  localparam int FB_IDX_DLY = LOOP_DLY - PD_IDX_STAGES;
  localparam int SMP_W      = 2*IW;

  logic                 idx_vld, mul_vld;
  logic [AW-1:0]        idx;
  logic signed [CW-1:0] coef_i, coef_q;
  logic [SMP_W-1:0]     al_smp;
  logic [SMP_W:0]       fb_bus;

  pd_power_index #(.IW(IW), .AW(AW)) u_idx (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .o_vld(idx_vld), .o_idx(idx)
  );

  pd_corr_table #(.AW(AW), .CW(CW)) u_tbl (
    .clk(clk), .rst(rst), .rd_addr(idx), .rd_i(coef_i), .rd_q(coef_q),
    .wr_en(tw_en), .wr_addr(tw_addr), .wr_i(tw_i), .wr_q(tw_q)
  );

  pd_delay #(.W(1), .N(PD_RD_STAGES)) u_vld_dly (
    .clk(clk), .rst(rst), .d(idx_vld), .q(mul_vld)
  );

  pd_delay #(.W(SMP_W), .N(ALIGN)) u_smp_dly (
    .clk(clk), .rst(rst), .d({in_i, in_q}), .q(al_smp)
  );

  pd_cmul #(.IW(IW), .CW(CW)) u_mul (
    .clk(clk), .rst(rst), .in_vld(mul_vld),
    .x_i(al_smp[SMP_W-1:IW]), .x_q(al_smp[IW-1:0]),
    .c_i(coef_i), .c_q(coef_q),
    .o_vld(pd_vld), .o_i(pd_i), .o_q(pd_q)
  );

  pd_delay #(.W(SMP_W+1), .N(LOOP_DLY)) u_fb_smp (
    .clk(clk), .rst(rst), .d({in_vld, in_i, in_q}), .q(fb_bus)
  );

  pd_delay #(.W(AW), .N(FB_IDX_DLY)) u_fb_idx (
    .clk(clk), .rst(rst), .d(idx), .q(fb_idx)
  );

  assign fb_vld = fb_bus[SMP_W];
  assign fb_i   = fb_bus[SMP_W-1:IW];
  assign fb_q   = fb_bus[IW-1:0];

endmodule

// File: tb/sim_lut_predistorter.sv
module sim_lut_predistorter;
  localparam int IW = 14, CW = 12, AW = 8, LOOP = 12;
  localparam int DEPTH = 1 << AW, FRAC = CW - 2, UNITY = 1 << FRAC;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic in_vld = 0, tw_en = 0;
  logic signed [IW-1:0] in_i = '0, in_q = '0;
  logic [AW-1:0] tw_addr = '0;
  logic signed [CW-1:0] tw_i = '0, tw_q = '0;
  logic pd_vld, fb_vld;
  logic signed [IW-1:0] pd_i, pd_q, fb_i, fb_q;
  logic [AW-1:0] fb_idx;

  lut_predistorter #(.IW(IW), .CW(CW), .AW(AW), .LOOP_DLY(LOOP)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .tw_en(tw_en), .tw_addr(tw_addr), .tw_i(tw_i), .tw_q(tw_q),
    .pd_vld(pd_vld), .pd_i(pd_i), .pd_q(pd_q),
    .fb_vld(fb_vld), .fb_i(fb_i), .fb_q(fb_q), .fb_idx(fb_idx));

  typedef struct { int i; int q; int idx; int due; string req; } exp_t;
  typedef struct { int i; int q; int cap; string req; } pend_t;
  exp_t q_pd[$], q_fb[$];
  pend_t pend[$];
  int mi[DEPTH], mq[DEPTH];
  bit tbl_ready = 0, done = 0;
  int n_chk = 0, n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic int idx_of(int i, int q);
    longint p = longint'(i) * i + longint'(q) * q;
    if (p >= (64'sd1 << (2*IW-1))) return DEPTH - 1;
    return int'(p >>> (2*IW-1-AW));
  endfunction

  function automatic int clampv(longint v);
    if (v > (1 << (IW-1)) - 1) return (1 << (IW-1)) - 1;
    if (v < -(1 << (IW-1))) return -(1 << (IW-1));
    return int'(v);
  endfunction

  function automatic int rnd(longint v);
    return clampv((v + (1 << (FRAC-1))) >>> FRAC);
  endfunction

  task automatic check(string req, bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock of stimulus; entered and left just after a rising edge
  task automatic step(bit v, int xi, int xq, string req,
                      bit we = 0, int wa = 0, int wi = 0, int wq = 0);
    int n = cyc + 1;  // edge that captures these inputs
    while (pend.size() > 0 && pend[0].cap == n - 2) begin
      pend_t p = pend.pop_front();
      int k = idx_of(p.i, p.q);
      exp_t e;
      e.i = rnd(longint'(p.i) * mi[k] - longint'(p.q) * mq[k]);
      e.q = rnd(longint'(p.i) * mq[k] + longint'(p.q) * mi[k]);
      e.idx = k; e.due = p.cap + 4; e.req = p.req;
      q_pd.push_back(e);
    end
    if (we && tbl_ready) begin mi[wa] = wi; mq[wa] = wq; end
    if (v) begin
      pend_t p;
      exp_t f;
      p.i = xi; p.q = xq; p.cap = n; p.req = req;
      pend.push_back(p);
      f.i = xi; f.q = xq; f.idx = idx_of(xi, xq); f.due = n + LOOP - 1; f.req = req;
      q_fb.push_back(f);
    end
    in_vld = v; in_i = IW'(xi); in_q = IW'(xq);
    tw_en = we; tw_addr = AW'(wa); tw_i = CW'(wi); tw_q = CW'(wq);
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, "");
  endtask

  function automatic int rnd_bits(int w);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'($signed(seed[31 -: 16])) >>> (16 - w);
  endfunction

  // Monitor: compares outputs against the queued expectations
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      if (pd_vld) begin
        if (q_pd.size() == 0) check("R9", 0, "pd_vld with nothing pending", 1, 0);
        else begin
          e = q_pd.pop_front();
          check(e.req, int'(pd_i) == e.i, "pd_i", int'(pd_i), e.i);
          check(e.req, int'(pd_q) == e.q, "pd_q", int'(pd_q), e.q);
          check("R9", cyc == e.due, "pd cycle", cyc, e.due);
        end
      end
      if (fb_vld) begin
        if (q_fb.size() == 0) check("R9", 0, "fb_vld with nothing pending", 1, 0);
        else begin
          e = q_fb.pop_front();
          check("R8", int'(fb_i) == e.i && int'(fb_q) == e.q, "fb sample i", int'(fb_i), e.i);
          check("R1", int'(fb_idx) == e.idx, "fb_idx", int'(fb_idx), e.idx);
          check("R8", cyc == e.due, "fb cycle", cyc, e.due);
        end
      end
    end
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) begin mi[k] = UNITY; mq[k] = 0; end
    repeat (200000) @(posedge clk);
    if (!done) begin
      check("R9", 0, "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int a;
    // Reset with active stimulus: outputs stay cleared (R9)
    in_vld = 1; in_i = 14'sd1234; in_q = -14'sd77;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R9", pd_vld == 0 && fb_vld == 0, "valids in reset", int'(pd_vld), 0);
    check("R9", pd_i == 0 && pd_q == 0, "pd in reset", int'(pd_i), 0);
    check("R8", fb_i == 0 && fb_idx == 0, "fb in reset", int'(fb_i), 0);
    @(posedge clk); #1;
    rst = 0; in_vld = 0;
    // Fill phase; a write to address 19 here must be dropped (R3)
    idle(100);
    step(0, 0, 0, "", 1, idx_of(3000, -1000), 0, 0);
    idle(DEPTH);
    tbl_ready = 1;

    // Unity table: pass-through and address corners (R1, R2)
    step(1, 0, 0, "R2");
    step(1, 8191, 0, "R2");
    step(1, -8192, -8192, "R1");
    step(1, 3000, -1000, "R3");
    step(0, 0, 0, "");
    step(1, -5000, 4000, "R2");
    step(1, 1, -1, "R2");
    idle(LOOP + 2);

    // Rotation by j at one address, neighbour untouched (R4, R6)
    a = idx_of(3000, -1000);
    step(0, 0, 0, "", 1, a, 0, UNITY);
    step(1, 3000, -1000, "R4");
    step(1, -5000, 4000, "R6");
    step(1, 3001, -1000, "R4");
    idle(6);

    // Clamping at both rails (R5)
    a = idx_of(8000, 8000);
    step(0, 0, 0, "", 1, a, 2047, 2047);
    step(1, 8000, 8000, "R5");
    step(0, 0, 0, "", 1, a, -2048, 0);
    step(1, 8000, 8000, "R5");
    step(1, 100, 100, "R4");
    idle(6);

    // Same-address collision: write at read edge unseen, one edge earlier seen (R7)
    a = idx_of(3000, -1000);
    step(1, 3000, -1000, "R7");
    step(0, 0, 0, "");
    step(0, 0, 0, "", 1, a, UNITY/2, 0);
    step(1, 3000, -1000, "R7");
    step(0, 0, 0, "", 1, a, -UNITY, 0);
    idle(LOOP + 2);

    // Random streaming with gaps and concurrent writes (R4, R7, R9)
    for (int k = 0; k < 600; k++) begin
      int xi = rnd_bits(IW), xq = rnd_bits(IW);
      bit v = (rnd_bits(4) != 0);
      bit w = (k % 3 == 0);
      step(v, xi, xq, "R4", w, rnd_bits(AW) & (DEPTH-1), rnd_bits(CW), rnd_bits(CW));
    end
    idle(LOOP + 4);

    check("R9", q_pd.size() == 0, "pd items left", q_pd.size(), 0);
    check("R8", q_fb.size() == 0, "fb items left", q_fb.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule